// File: doc/BRIEF.md
# Reset and Wake-Up Start-Up Sequencer

This block decides when a small microcontroller core may run. It watches an asynchronous power-on input, a synchronous reset request, a power-down entry strobe from the core and a wake event, all on the system clock. After power-on or a reset request it holds the core in reset for an oscillator settle interval and then for a further option-load interval. After a wake from power-down it only stalls the core for the settle interval, without reset, so execution resumes where it stopped.

While the core is held in reset, the block also drives the level flags that force core state to its reset values. These cover the program counter load of zero, interrupt masking, prescaler clear, timer stop, port input direction, stack pointer initialisation and watchdog clear. The watchdog is told to count as soon as the reset hold ends. All interfaces are plain control levels and strobes: there is no data stream, so no valid/ready handshake applies.

Top module: `startup_sequencer`

## Requirements
- R1: While `por_n` is low, `core_rst_o` is 1 and both `run_o` and `settled_o` are 0.
- R2: After `por_n` rises, `settled_o` rises on the 1024th rising clock edge (parameter SETTLE_CYC) and not before.
- R3: After the settle interval, `core_rst_o` stays 1 for LOAD_CYC more edges (default 16). `core_rst_o` falls and `run_o` rises on the same edge, which is edge 1040 by default.
- R4: A `rst_req` sampled high in any state gives `core_rst_o`=1, `run_o`=0 and `settled_o`=0 after that edge. The counts hold at zero while it stays high, and the R2/R3 timing restarts from the first edge on which it is sampled low.
- R5: A `pd_enter` sampled high while `run_o` is 1 clears `run_o` and `settled_o` on that edge. `core_rst_o` stays 0.
- R6: A `wake` sampled high during power-down sets `run_o` and `settled_o` on the 1024th following edge. There is no option-load interval, and `core_rst_o` stays 0 throughout.
- R7: A `rst_req` during the wake stall starts the full reset sequence of R4, including the option-load interval.
- R8: `pd_enter` has no effect unless `run_o` is 1, and `wake` has no effect unless the block is in power-down. Timing and outputs are unchanged by either.
- R9: `pc_clear_o`, `irq_mask_o`, `presc_clear_o`, `tmr_stop_o`, `port_input_o` and `sp_init_o` each equal `core_rst_o`. Each is 1 during the reset hold and 0 otherwise.
- R10: `wdt_clear_o` equals `core_rst_o`, and `wdt_run_o` is its inverse, so the watchdog counts from the edge where the hold ends.
- R11: If `rst_req` and `pd_enter` are high on the same edge, the reset wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_req | input | 1 | Synchronous reset request, active high |
| pd_enter | input | 1 | Power-down entry strobe from the core |
| wake | input | 1 | Wake-up event |
| core_rst_o | output | 1 | Core held in reset |
| run_o | output | 1 | Core may execute (registered) |
| settled_o | output | 1 | Oscillator settle interval completed |
| pc_clear_o | output | 1 | Force program counter load to zero |
| irq_mask_o | output | 1 | Force interrupts disabled |
| presc_clear_o | output | 1 | Clear the prescaler |
| tmr_stop_o | output | 1 | Switch timer/event counters off |
| port_input_o | output | 1 | Force all I/O ports to input |
| sp_init_o | output | 1 | Set stack pointer to top of stack |
| wdt_clear_o | output | 1 | Clear the watchdog count |
| wdt_run_o | output | 1 | Allow the watchdog to count |

## Verification
Two functions can fall in the same cycle. The first pair is a reset request and power-down entry while running. The second pair is a reset request and the last cycle of a wake stall, which would otherwise release the core. Directed cases place `rst_req` exactly on the `pd_enter` edge and in the middle of a wake stall; the constrained random phase lets the three inputs collide freely. Every cycle is judged against a bench model in which the reset request always takes priority, and the model then checks the full 1040-edge restart.

// File: rtl/sseq_pkg.sv
package sseq_pkg;
  typedef enum logic [2:0] {
    PH_COLD  = 3'd0,  // reset hold, settle interval
    PH_OPTLD = 3'd1,  // reset hold, option-load interval
    PH_RUN   = 3'd2,  // executing
    PH_SLEEP = 3'd3,  // power-down
    PH_WARM  = 3'd4   // wake stall, settle interval only
  } phase_t;
endpackage

// File: rtl/sseq_counter.sv
module sseq_counter #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic por_n,
  input  logic clr,
  input  logic en,
  output logic last
);
  localparam int W = $clog2(LIMIT) + 1;

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (en)  cnt <= cnt + 1'b1;
  end

  // terminal count: this enabled cycle is the final one of the interval
  assign last = en && (cnt == W'(LIMIT - 1));
endmodule

// File: rtl/sseq_fsm.sv
module sseq_fsm
  import sseq_pkg::*;
(
  input  logic   clk,
  input  logic   por_n,
  input  logic   rst_req,
  input  logic   pd_enter,
  input  logic   wake,
  input  logic   settle_last,
  input  logic   load_last,
  output phase_t phase,
  output logic   settle_en,
  output logic   settle_clr,
  output logic   load_en,
  output logic   load_clr,
  output logic   ready_q,
  output logic   settled_q
);
  phase_t nxt;

  assign settle_en  = (phase == PH_COLD) || (phase == PH_WARM);
  assign settle_clr = rst_req || !settle_en || settle_last;
  assign load_en    = (phase == PH_OPTLD);
  assign load_clr   = rst_req || !load_en || load_last;

  always_comb begin
    nxt = phase;
    if (rst_req) begin
      nxt = PH_COLD;  // reset request outranks every other event
    end else begin
      unique case (phase)
        PH_COLD:  if (settle_last) nxt = PH_OPTLD;
        PH_OPTLD: if (load_last)   nxt = PH_RUN;
        PH_RUN:   if (pd_enter)    nxt = PH_SLEEP;
        PH_SLEEP: if (wake)        nxt = PH_WARM;
        PH_WARM:  if (settle_last) nxt = PH_RUN;
        default:                   nxt = PH_COLD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      phase     <= PH_COLD;
      ready_q   <= 1'b0;
      settled_q <= 1'b0;
    end else begin
      phase     <= nxt;
      ready_q   <= (nxt == PH_RUN);
      settled_q <= (nxt == PH_RUN) || (nxt == PH_OPTLD);
    end
  end
endmodule

// File: rtl/sseq_flags.sv
module sseq_flags
  import sseq_pkg::*;
(
  input  phase_t phase,
  output logic   hold,
  output logic   pc_clear,
  output logic   irq_mask,
  output logic   presc_clear,
  output logic   tmr_stop,
  output logic   port_input,
  output logic   sp_init,
  output logic   wdt_clear,
  output logic   wdt_run
);
  assign hold        = (phase == PH_COLD) || (phase == PH_OPTLD);
  assign pc_clear    = hold;
  assign irq_mask    = hold;
  assign presc_clear = hold;
  assign tmr_stop    = hold;
  assign port_input  = hold;
  assign sp_init     = hold;
  assign wdt_clear   = hold;
  assign wdt_run     = !hold;  // count starts the edge the hold ends
endmodule

// File: rtl/startup_sequencer.sv
module startup_sequencer
  import sseq_pkg::*;
#(
  parameter int SETTLE_CYC = 1024,
  parameter int LOAD_CYC   = 16
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_req,
  input  logic pd_enter,
  input  logic wake,
  output logic core_rst_o,
  output logic run_o,
  output logic settled_o,
  output logic pc_clear_o,
  output logic irq_mask_o,
  output logic presc_clear_o,
  output logic tmr_stop_o,
  output logic port_input_o,
  output logic sp_init_o,
  output logic wdt_clear_o,
  output logic wdt_run_o
);
  phase_t phase;
  logic   settle_en, settle_clr, settle_last;
  logic   load_en, load_clr, load_last;

  sseq_counter #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk(clk), .por_n(por_n), .clr(settle_clr), .en(settle_en), .last(settle_last)
  );

  sseq_counter #(.LIMIT(LOAD_CYC)) u_load (
    .clk(clk), .por_n(por_n), .clr(load_clr), .en(load_en), .last(load_last)
  );

  sseq_fsm u_fsm (
    .clk(clk), .por_n(por_n), .rst_req(rst_req), .pd_enter(pd_enter), .wake(wake),
    .settle_last(settle_last), .load_last(load_last), .phase(phase),
    .settle_en(settle_en), .settle_clr(settle_clr),
    .load_en(load_en), .load_clr(load_clr),
    .ready_q(run_o), .settled_q(settled_o)
  );

  sseq_flags u_flags (
    .phase(phase), .hold(core_rst_o), .pc_clear(pc_clear_o), .irq_mask(irq_mask_o),
    .presc_clear(presc_clear_o), .tmr_stop(tmr_stop_o), .port_input(port_input_o),
    .sp_init(sp_init_o), .wdt_clear(wdt_clear_o), .wdt_run(wdt_run_o)
  );
endmodule

// File: rtl/sseq_chk.sv
module sseq_chk #(
  parameter int SETTLE_CYC = 1024,
  parameter int LOAD_CYC   = 16
) (
  input logic clk,
  input logic por_n,
  input logic rst_req,
  input logic pd_enter,
  input logic wake,
  input logic core_rst_o,
  input logic run_o,
  input logic settled_o
);
  localparam int TOTAL = SETTLE_CYC + LOAD_CYC;
  localparam int HW    = $clog2(TOTAL) + 2;

  logic [HW-1:0] hold_cnt;
  logic [HW-1:0] warm_cnt;
  logic          warm_f;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      hold_cnt <= '0;
      warm_cnt <= '0;
      warm_f   <= 1'b0;
    end else begin
      if (rst_req)         hold_cnt <= '0;
      else if (core_rst_o) hold_cnt <= hold_cnt + 1'b1;
      else                 hold_cnt <= '0;

      if (rst_req || core_rst_o || run_o) warm_f <= 1'b0;
      else if (wake)                      warm_f <= 1'b1;

      if (rst_req || core_rst_o || run_o) warm_cnt <= '0;
      else if (warm_f)                    warm_cnt <= warm_cnt + 1'b1;
    end
  end

  // R1
  excl_run_chk: assert property (@(posedge clk) disable iff (!por_n)
    core_rst_o |-> !run_o);

  // R2
  run_settled_chk: assert property (@(posedge clk) disable iff (!por_n)
    run_o |-> settled_o);

  // R3
  hold_len_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(core_rst_o) |-> (hold_cnt == HW'(TOTAL)) && run_o);

  // R4
  req_restart_chk: assert property (@(posedge clk) disable iff (!por_n)
    rst_req |=> core_rst_o && !run_o && !settled_o);

  // R5
  pd_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
    run_o && pd_enter && !rst_req |=> !run_o && !settled_o && !core_rst_o);

  // R6
  wake_len_chk: assert property (@(posedge clk) disable iff (!por_n)
    $rose(run_o) && warm_f |-> warm_cnt == HW'(SETTLE_CYC));
endmodule

bind startup_sequencer sseq_chk #(.SETTLE_CYC(SETTLE_CYC), .LOAD_CYC(LOAD_CYC)) u_chk (.*);

// File: tb/tb_startup_sequencer.sv
`timescale 1ns/1ps
module tb_startup_sequencer;
  localparam int SET = 1024;
  localparam int LD  = 16;

  logic clk = 1'b0;
  logic por_n = 1'b0, rst_req = 1'b0, pd_enter = 1'b0, wake = 1'b0;
  logic core_rst_o, run_o, settled_o, pc_clear_o, irq_mask_o, presc_clear_o;
  logic tmr_stop_o, port_input_o, sp_init_o, wdt_clear_o, wdt_run_o;

  int errors = 0, checks = 0;
  bit finished = 0;
  int m_ph = 0;  // 0 cold, 1 option load, 2 run, 3 sleep, 4 warm
  int m_cnt = 0;

  always #2.5 clk = ~clk;

  startup_sequencer dut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    if (!por_n || rst_req) begin m_ph = 0; m_cnt = 0; end
    else case (m_ph)
      0: if (m_cnt == SET-1) begin m_ph = 1; m_cnt = 0; end else m_cnt++;
      1: if (m_cnt == LD-1)  begin m_ph = 2; m_cnt = 0; end else m_cnt++;
      2: if (pd_enter) m_ph = 3;
      3: if (wake) begin m_ph = 4; m_cnt = 0; end
      default: if (m_cnt == SET-1) begin m_ph = 2; m_cnt = 0; end else m_cnt++;
    endcase
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
    end
  endtask

  task automatic check_model(string tag);
    int h;
    h = (m_ph <= 1) ? 1 : 0;
    chk({tag, " R4 core_rst"}, core_rst_o, h);
    chk({tag, " R5 run"}, run_o, (m_ph == 2) ? 1 : 0);
    chk({tag, " R6 settled"}, settled_o, (m_ph == 1 || m_ph == 2) ? 1 : 0);
    chk({tag, " R9 flags"}, {pc_clear_o, irq_mask_o, presc_clear_o, tmr_stop_o,
        port_input_o, sp_init_o}, h ? 63 : 0);
    chk({tag, " R10 wdt"}, {wdt_clear_o, wdt_run_o}, h ? 2 : 1);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    // R1: power-on hold
    chk("R1 core_rst in por", core_rst_o, 1);
    chk("R1 run in por", run_o, 0);
    chk("R1 settled in por", settled_o, 0);
    chk("R9 flags in por", {pc_clear_o, irq_mask_o, presc_clear_o, tmr_stop_o,
        port_input_o, sp_init_o}, 63);
    chk("R10 wdt in por", {wdt_clear_o, wdt_run_o}, 2);
    por_n = 1'b1;
    m_ph = 0; m_cnt = 0;
    tick(SET-1);
    chk("R2 settled before 1024", settled_o, 0);
    tick(1);
    chk("R2 settled at 1024", settled_o, 1);
    chk("R3 core_rst at 1024", core_rst_o, 1);
    tick(LD-1);
    chk("R3 core_rst at 1039", core_rst_o, 1);
    chk("R3 run at 1039", run_o, 0);
    tick(1);
    chk("R3 core_rst at 1040", core_rst_o, 0);
    chk("R3 run at 1040", run_o, 1);
    chk("R9 flags released", {pc_clear_o, irq_mask_o, presc_clear_o, tmr_stop_o,
        port_input_o, sp_init_o}, 0);
    chk("R10 wdt runs", {wdt_clear_o, wdt_run_o}, 1);

    // R8: wake while running is ignored
    wake = 1'b1; tick(1); wake = 1'b0; tick(2);
    chk("R8 wake in run: run", run_o, 1);
    chk("R8 wake in run: settled", settled_o, 1);

    // R5: power-down entry
    pd_enter = 1'b1; tick(1); pd_enter = 1'b0;
    chk("R5 run cleared", run_o, 0);
    chk("R5 settled cleared", settled_o, 0);
    chk("R5 core_rst low", core_rst_o, 0);
    pd_enter = 1'b1; tick(3); pd_enter = 1'b0;
    chk("R8 pd in sleep: run", run_o, 0);

    // R6: wake stall only
    wake = 1'b1; tick(1); wake = 1'b0;
    tick(SET-1);
    chk("R6 run before 1024", run_o, 0);
    chk("R6 core_rst stays low", core_rst_o, 0);
    tick(1);
    chk("R6 run at 1024", run_o, 1);
    chk("R6 settled at 1024", settled_o, 1);

    // R7: reset request during the wake stall
    pd_enter = 1'b1; tick(1); pd_enter = 1'b0;
    wake = 1'b1; tick(1); wake = 1'b0;
    tick(500);
    rst_req = 1'b1; tick(3);
    chk("R7 core_rst during req", core_rst_o, 1);
    chk("R4 settled during req", settled_o, 0);
    rst_req = 1'b0;
    pd_enter = 1'b1; wake = 1'b1; tick(5); pd_enter = 1'b0; wake = 1'b0;  // R8
    tick(SET + LD - 6);
    chk("R7 core_rst at 1039", core_rst_o, 1);
    chk("R8 pd/wake in hold: settled", settled_o, 1);
    tick(1);
    chk("R7 run at 1040", run_o, 1);

    // R11: simultaneous reset request and power-down entry
    rst_req = 1'b1; pd_enter = 1'b1; tick(1); rst_req = 1'b0; pd_enter = 1'b0;
    chk("R11 reset wins: core_rst", core_rst_o, 1);
    chk("R11 reset wins: run", run_o, 0);
    tick(SET + LD - 1);
    chk("R11 run at 1039", run_o, 0);
    tick(1);
    chk("R11 run at 1040", run_o, 1);

    // random phase against the bench model
    for (int c = 0; c < 40000; c++) begin
      rst_req  = ($urandom % 4000) == 0;
      pd_enter = ($urandom % 150) == 0;
      wake     = ($urandom % 80) == 0;
      tick(1);
      check_model("rand");
    end
    rst_req = 1'b0; pd_enter = 1'b0; wake = 1'b0;

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule